// File: doc/BRIEF.md
# Bypass Connection and Buffer Controller

This block is the host-facing command engine of an offload chip that carries the data transfer phase of a protocol stack in hardware. It keeps a small table of per-connection control blocks and decodes four host commands: open a bypassed connection, move a packet into the chip, drain a connection back to the software stack, and re-enter the bypass after software has updated the window. The host can also read and write any control-block word directly through a register port.

Packets land in a pool of fixed-size on-chip buffers that are handed out strictly in rotation. Each buffer moves through four states: free, being filled, filled, and consumed. A transfer command takes the next buffer in rotation and emits a one-cycle request to an external DMA mover, carrying the host source address, the length and the chip-side destination address of that buffer. The processing engine is told which buffer is filled and waiting. It then marks buffers consumed and later releases them. A drain command for a connection holds until none of that connection's buffers are still being filled or are waiting. It then signals completion so the host can read back the updated window words.

Top module: `bypass_conn_ctrl`

## Requirements
- R1: After reset every buffer is free, the rotation points at buffer 0, all control-block words read 0, and `full`, `host_tag`, `sync_done`, `xfer_err`, `dma_go` and `rdy_valid` are 0.
- R2: An open command (`cmd_op`=0) writes `cmd_seq`, `cmd_lwe`, `cmd_uwe` and `cmd_dref` into words 0, 1, 2 and 3 of the named connection's control block.
- R3: A restart command (`cmd_op`=3) writes words 0, 1 and 2 only; word 3, the destination reference, keeps its value.
- R4: The register port addresses word `reg_addr[2:0]` of connection `reg_addr[5:3]`. Eight words exist per connection: 0 sequence, 1 lower window edge, 2 upper window edge, 3 destination reference, 4 class, 5 format, 6 options, 7 presentation context. A read of a connection number of `NCONN` or above returns 0. A write to such a number, or a write in a cycle with `cmd_valid` high, is ignored.
- R5: A transfer command (`cmd_op`=1) accepted while `full` is 0 produces, one cycle later, a one-cycle `dma_go` with `dma_src`=`cmd_src`, `dma_len`=`cmd_len` and `dma_dst`=`BUF_BASE`+index*`BUF_BYTES`. Buffer indices are taken 0,1,..,`NBUF`-1 and then wrap.
- R6: `full` is 1 exactly when the next buffer in rotation is not free. A transfer command given while `full` is 1 produces no `dma_go`, leaves all buffers unchanged and sets `xfer_err`. The next accepted transfer clears `xfer_err`.
- R7: Buffer states advance only free→filling (transfer), filling→filled (`dma_done` naming it), filled→consumed (`eng_take` naming it), and consumed→free (`eng_rel` naming it). Any of these events aimed at a buffer in another state is ignored.
- R8: `rdy_valid` is 1 when any buffer is filled. `rdy_buf` is then the lowest-numbered filled buffer.
- R9: `host_tag` is 1 in the cycle after any accepted command. It stays 1 while a drain is pending.
- R10: A drain command (`cmd_op`=2) completes in the first cycle in which no buffer owned by that connection is filling or filled. One cycle later, `sync_done` pulses for one cycle and `host_tag` drops. Commands arriving while a drain is pending are ignored.
- R11: Commands naming a connection of `NCONN` or above are ignored and do not set `host_tag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Host command strobe |
| cmd_op | input | 2 | 0 open, 1 transfer, 2 drain, 3 restart |
| cmd_conn | input | 3 | Connection index |
| cmd_seq | input | 32 | Sequence number for open/restart |
| cmd_lwe | input | 32 | Lower window edge for open/restart |
| cmd_uwe | input | 32 | Upper window edge for open/restart |
| cmd_dref | input | 32 | Destination reference for open |
| cmd_src | input | 32 | Host source address for transfer |
| cmd_len | input | 16 | Packet length for transfer |
| host_tag | output | 1 | Command received / drain in progress |
| sync_done | output | 1 | Drain completion pulse |
| full | output | 1 | Next buffer in rotation is not free |
| xfer_err | output | 1 | Last transfer rejected for lack of space |
| dma_go | output | 1 | DMA request pulse |
| dma_src | output | 32 | DMA source address |
| dma_dst | output | 32 | DMA destination buffer address |
| dma_len | output | 16 | DMA length |
| dma_done | input | 1 | DMA finished into a buffer |
| dma_done_buf | input | 2 | Buffer the DMA finished |
| eng_take | input | 1 | Engine consumes a buffer |
| eng_take_buf | input | 2 | Buffer consumed |
| eng_rel | input | 1 | Engine releases a buffer |
| eng_rel_buf | input | 2 | Buffer released |
| rdy_valid | output | 1 | Some buffer is filled |
| rdy_buf | output | 2 | Lowest filled buffer |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | {connection, word} |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |

## Verification
Transfers are issued until the rotation wraps and the pool is full. This shows that the destination addresses follow buffer order and that a rejected transfer neither moves the rotation nor emits a request. Engine events are aimed at buffers in the wrong state next to correct ones, so an ignored event can be told apart from a wrongly applied one through `full` and `rdy_buf`. Drains are run in two cases: one against a connection that still owns a filling buffer, where completion must wait for the consume step, and one against an idle connection, which completes in the next cycle. A command issued during a pending drain is checked to leave the control blocks untouched.

// File: rtl/bypass_conn_ctrl.sv
module bypass_conn_ctrl #(
  parameter int NCONN = 5,
  parameter int NBUF = 4,
  parameter int BUF_BYTES = 1024,
  parameter int BUF_BASE = 32'h0000_1000,
  parameter int LEN_W = 16,
  localparam int CW = $clog2(NCONN),
  localparam int BW = (NBUF > 1) ? $clog2(NBUF) : 1,
  localparam int AW = CW + 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [CW-1:0]    cmd_conn,
  input  logic [31:0]      cmd_seq,
  input  logic [31:0]      cmd_lwe,
  input  logic [31:0]      cmd_uwe,
  input  logic [31:0]      cmd_dref,
  input  logic [31:0]      cmd_src,
  input  logic [LEN_W-1:0] cmd_len,
  output logic             host_tag,
  output logic             sync_done,
  output logic             full,
  output logic             xfer_err,
  output logic             dma_go,
  output logic [31:0]      dma_src,
  output logic [31:0]      dma_dst,
  output logic [LEN_W-1:0] dma_len,
  input  logic             dma_done,
  input  logic [BW-1:0]    dma_done_buf,
  input  logic             eng_take,
  input  logic [BW-1:0]    eng_take_buf,
  input  logic             eng_rel,
  input  logic [BW-1:0]    eng_rel_buf,
  output logic             rdy_valid,
  output logic [BW-1:0]    rdy_buf,
  input  logic             reg_wr,
  input  logic [AW-1:0]    reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata
);
  localparam logic [1:0] S_FREE = 2'd0, S_FILLING = 2'd1, S_FILLED = 2'd2, S_DONE = 2'd3;
  localparam logic [CW:0] NCONN_V = NCONN[CW:0];
  localparam int NWORDS = NCONN * 8;

  logic [31:0]   cb [NWORDS];
  logic [1:0]    st [NBUF];
  logic [CW-1:0] owner [NBUF];
  logic [BW-1:0] wp;
  logic          sync_pend;
  logic [CW-1:0] sync_conn;
  logic          drained;
  logic [2*NBUF-1:0] st_flat;

  wire acc      = cmd_valid && ({1'b0, cmd_conn} < NCONN_V) && !sync_pend;
  wire is_start = acc && cmd_op == 2'd0;
  wire is_xfer  = acc && cmd_op == 2'd1;
  wire is_sync  = acc && cmd_op == 2'd2;
  wire is_rest  = acc && cmd_op == 2'd3;
  wire xfer_ok  = is_xfer && !full;
  wire rd_ok    = {1'b0, reg_addr[AW-1:3]} < NCONN_V;

  assign full = st[wp] != S_FREE;
  assign reg_rdata = rd_ok ? cb[reg_addr] : 32'd0;

  always_comb begin
    drained = 1'b1;
    rdy_valid = 1'b0;
    rdy_buf = '0;
    for (int i = NBUF - 1; i >= 0; i--) begin
      if (owner[i] == sync_conn && (st[i] == S_FILLING || st[i] == S_FILLED)) drained = 1'b0;
      if (st[i] == S_FILLED) begin
        rdy_valid = 1'b1;
        rdy_buf = BW'(i);
      end
    end
  end

  always_comb
    for (int i = 0; i < NBUF; i++) st_flat[2*i +: 2] = st[i];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NWORDS; i++) cb[i] <= '0;
    end else if (is_start || is_rest) begin
      cb[{cmd_conn, 3'd0}] <= cmd_seq;
      cb[{cmd_conn, 3'd1}] <= cmd_lwe;
      cb[{cmd_conn, 3'd2}] <= cmd_uwe;
      if (is_start) cb[{cmd_conn, 3'd3}] <= cmd_dref;
    end else if (reg_wr && rd_ok && !cmd_valid) begin
      cb[reg_addr] <= reg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NBUF; i++) begin
        st[i] <= S_FREE;
        owner[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NBUF; i++) begin
        if (xfer_ok && wp == BW'(i)) begin
          st[i] <= S_FILLING;
          owner[i] <= cmd_conn;
        end else if (dma_done && dma_done_buf == BW'(i) && st[i] == S_FILLING) st[i] <= S_FILLED;
        else if (eng_take && eng_take_buf == BW'(i) && st[i] == S_FILLED) st[i] <= S_DONE;
        else if (eng_rel && eng_rel_buf == BW'(i) && st[i] == S_DONE) st[i] <= S_FREE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0;
      sync_pend <= 1'b0;
      sync_conn <= '0;
      host_tag <= 1'b0;
      sync_done <= 1'b0;
      xfer_err <= 1'b0;
      dma_go <= 1'b0;
      dma_src <= '0;
      dma_dst <= '0;
      dma_len <= '0;
    end else begin
      dma_go <= xfer_ok;
      if (is_xfer) xfer_err <= full;
      if (xfer_ok) begin
        wp <= (wp == BW'(NBUF - 1)) ? '0 : wp + 1'b1;
        dma_src <= cmd_src;
        dma_len <= cmd_len;
        dma_dst <= 32'(BUF_BASE) + 32'(wp) * 32'(BUF_BYTES);
      end
      if (is_sync) begin
        sync_pend <= 1'b1;
        sync_conn <= cmd_conn;
      end else if (sync_pend && drained) sync_pend <= 1'b0;
      sync_done <= sync_pend && drained;
      host_tag <= acc || (sync_pend && !drained);
    end
  end
endmodule

// File: rtl/bypass_conn_ctrl_chk.sv
module bypass_conn_ctrl_chk #(
  parameter int NCONN = 5,
  parameter int NBUF = 4,
  parameter int CW = 3,
  parameter int BW = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [1:0]        cmd_op,
  input logic [CW-1:0]     cmd_conn,
  input logic              sync_pend,
  input logic              full,
  input logic              dma_go,
  input logic              xfer_err,
  input logic              sync_done,
  input logic              host_tag,
  input logic              rdy_valid,
  input logic [BW-1:0]     rdy_buf,
  input logic [2*NBUF-1:0] st_flat
);
  wire valid_conn = {1'b0, cmd_conn} < (CW+1)'(NCONN);

  p_reject_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd1 && valid_conn && !sync_pend && full) |=> (!dma_go && xfer_err));

  p_go_has_room_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dma_go |-> $past(!full && cmd_valid && cmd_op == 2'd1));

  p_done_ends_drain_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sync_done |-> ($past(sync_pend) && !host_tag));

  p_tag_while_drain_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_pend && $past(sync_pend) && !sync_done && $stable(sync_pend)) |-> host_tag);

  p_ready_is_filled_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_valid |-> st_flat[2*rdy_buf +: 2] == 2'd2);

  for (genvar i = 0; i < NBUF; i++) begin : g_buf
    p_status_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(st_flat[2*i +: 2]) |-> st_flat[2*i +: 2] == $past(st_flat[2*i +: 2]) + 2'd1);
  end
endmodule

bind bypass_conn_ctrl bypass_conn_ctrl_chk #(.NCONN(NCONN), .NBUF(NBUF), .CW(CW), .BW(BW)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_conn(cmd_conn),
  .sync_pend(sync_pend), .full(full), .dma_go(dma_go), .xfer_err(xfer_err),
  .sync_done(sync_done), .host_tag(host_tag), .rdy_valid(rdy_valid), .rdy_buf(rdy_buf),
  .st_flat(st_flat)
);

// File: tb/bypass_conn_ctrl_tb.sv
module bypass_conn_ctrl_tb_top;
  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic cmd_valid = 0; logic [1:0] cmd_op = 0; logic [2:0] cmd_conn = 0;
  logic [31:0] cmd_seq = 0, cmd_lwe = 0, cmd_uwe = 0, cmd_dref = 0, cmd_src = 0;
  logic [15:0] cmd_len = 0;
  logic host_tag, sync_done, full, xfer_err, dma_go, rdy_valid;
  logic [31:0] dma_src, dma_dst, reg_rdata;
  logic [15:0] dma_len;
  logic dma_done = 0, eng_take = 0, eng_rel = 0, reg_wr = 0;
  logic [1:0] dma_done_buf = 0, eng_take_buf = 0, eng_rel_buf = 0, rdy_buf;
  logic [5:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0;

  int checks = 0, fails = 0;
  bit finished = 0;

  bypass_conn_ctrl dut_i (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cmd(logic [1:0] op, logic [2:0] c, logic [31:0] s, logic [31:0] l,
                     logic [31:0] u, logic [31:0] d);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_conn = c;
    cmd_seq = s; cmd_lwe = l; cmd_uwe = u; cmd_dref = d;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic xfer(logic [2:0] c, logic [31:0] src, logic [15:0] len);
    cmd_src = src; cmd_len = len;
    cmd(2'd1, c, 0, 0, 0, 0);
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] v);
    reg_addr = a; #1; v = reg_rdata;
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic ev(int kind, logic [1:0] b);
    @(negedge clk);
    if (kind == 0) begin dma_done = 1; dma_done_buf = b; end
    else if (kind == 1) begin eng_take = 1; eng_take_buf = b; end
    else begin eng_rel = 1; eng_rel_buf = b; end
    @(negedge clk);
    dma_done = 0; eng_take = 0; eng_rel = 0;
  endtask

  // {write, addr, wdata, expected read}
  localparam logic [70:0] VEC [6] = '{
    {1'b1, 6'd12, 32'hA5A5_0001, 32'hA5A5_0001},
    {1'b1, 6'd39, 32'h0BAD_F00D, 32'h0BAD_F00D},
    {1'b1, 6'd40, 32'hFFFF_FFFF, 32'h0000_0000},
    {1'b0, 6'd12, 32'h0000_0000, 32'hA5A5_0001},
    {1'b1, 6'd5,  32'h0000_0077, 32'h0000_0077},
    {1'b0, 6'd30, 32'h0000_0000, 32'h0000_0000}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 full", full, 0); chk("R1 host_tag", host_tag, 0);
    chk("R1 xfer_err", xfer_err, 0); chk("R1 dma_go", dma_go, 0);
    chk("R1 rdy_valid", rdy_valid, 0); chk("R1 sync_done", sync_done, 0);
    rd(6'd3, v); chk("R1 cb zero", v, 0);

    // R4 register port vectors
    for (int i = 0; i < 6; i++) begin
      if (VEC[i][70]) wr(VEC[i][69:64], VEC[i][63:32]);
      rd(VEC[i][69:64], v); chk("R4 reg vector", v, VEC[i][31:0]);
    end

    // R2 open
    cmd(2'd0, 3'd2, 32'd10, 32'd10, 32'd74, 32'hBEEF);
    chk("R9 tag after open", host_tag, 1);
    rd(6'd16, v); chk("R2 seq", v, 10);
    rd(6'd18, v); chk("R2 uwe", v, 74);
    rd(6'd19, v); chk("R2 dref", v, 32'hBEEF);
    @(negedge clk); chk("R9 tag clears", host_tag, 0);

    // R3 restart
    cmd(2'd3, 3'd2, 32'd20, 32'd21, 32'd84, 32'h1111);
    rd(6'd16, v); chk("R3 seq", v, 20);
    rd(6'd17, v); chk("R3 lwe", v, 21);
    rd(6'd19, v); chk("R3 dref kept", v, 32'hBEEF);

    // R5 transfers in rotation
    xfer(3'd2, 32'h8000, 16'd100);
    chk("R5 go", dma_go, 1); chk("R5 dst0", dma_dst, 32'h1000);
    chk("R5 src", dma_src, 32'h8000); chk("R5 len", dma_len, 100);
    chk("R9 tag after xfer", host_tag, 1);
    xfer(3'd2, 32'h8400, 16'd200); chk("R5 dst1", dma_dst, 32'h1400);
    xfer(3'd3, 32'h8800, 16'd300); chk("R5 dst2", dma_dst, 32'h1800);
    xfer(3'd3, 32'h8C00, 16'd400); chk("R5 dst3", dma_dst, 32'h1C00);
    chk("R6 full after wrap", full, 1);
    xfer(3'd3, 32'h9000, 16'd5);
    chk("R6 no go when full", dma_go, 0); chk("R6 err set", xfer_err, 1);

    // R7/R8 lifecycle
    ev(0, 2'd0); chk("R8 rdy valid", rdy_valid, 1); chk("R8 rdy buf0", rdy_buf, 0);
    ev(0, 2'd2); chk("R8 lowest", rdy_buf, 0);
    ev(1, 2'd0); chk("R8 next filled", rdy_buf, 2);
    ev(1, 2'd1); chk("R7 take on filling ignored", rdy_buf, 2);
    ev(2, 2'd1); chk("R7 rel on filling ignored", full, 1);
    ev(2, 2'd0); chk("R7 rel frees buf0", full, 0);
    xfer(3'd1, 32'hA000, 16'd50);
    chk("R5 wrap dst", dma_dst, 32'h1000); chk("R6 err cleared", xfer_err, 0);
    chk("R6 full again", full, 1);

    // R10 drain conn2, owns buf1 (filling)
    cmd(2'd2, 3'd2, 0, 0, 0, 0);
    chk("R9 tag in drain", host_tag, 1); chk("R10 not done", sync_done, 0);
    cmd(2'd0, 3'd0, 32'd1, 32'd1, 32'd1, 32'h55);
    rd(6'd3, v); chk("R10 cmd ignored in drain", v, 0);
    ev(0, 2'd1); chk("R10 wait filled", sync_done, 0); chk("R9 tag held", host_tag, 1);
    ev(1, 2'd1); chk("R10 done lag", sync_done, 0);
    @(negedge clk);
    chk("R10 done pulse", sync_done, 1); chk("R10 tag drop", host_tag, 0);
    @(negedge clk); chk("R10 single pulse", sync_done, 0);
    chk("R8 after drain", rdy_buf, 2);

    // R10 drain idle conn4
    cmd(2'd2, 3'd4, 0, 0, 0, 0);
    chk("R10 idle tag", host_tag, 1);
    @(negedge clk); chk("R10 idle done", sync_done, 1);

    // R11 invalid connection
    @(negedge clk);
    cmd(2'd0, 3'd6, 32'd9, 32'd9, 32'd9, 32'd9);
    chk("R11 no tag", host_tag, 0);
    rd(6'd51, v); chk("R11 no write", v, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule